// File: doc/BRIEF.md
# UART Channel-Mode Data Path

This block is the byte-level data path of a UART. Received characters arrive from the deserializer, and a processor writes and reads a data port. A two-bit channel mode decides, byte by byte, whether traffic goes into the receive FIFO, the transmit FIFO, both, or neither. Each direction is gated by its own enable/disable pair held in a small control register. Each direction also has a reset bit that empties its FIFO and is never held in the register.

A receive-idle timer restarts whenever a byte enters the receive FIFO. If four character times pass with no new byte and the timeout setting is nonzero, the block pulses a timeout event. The character time is given as a number of bit ticks, and a bit-tick strobe from the baud generator advances the timer. Serializer timing is outside this block: the transmit side sees a push strobe with its byte, and pops the transmit FIFO head when it has sent that byte.

Top module: `uart_mode_router`

## Requirements
- R1: The control register `ctrl_o` resets to 9'h128. Its bits are: 0 clears RX, 1 clears TX, 2 enables RX, 3 disables RX, 4 enables TX, 5 disables TX, and 6 to 8 are stored only. After reset, neither FIFO accepts a byte.
- R2: In mode 0, received bytes go to the RX FIFO and processor writes go to the TX FIFO.
- R3: In mode 1, each received byte goes to both FIFOs, and processor writes are dropped.
- R4: In mode 2, processor writes go to the RX FIFO, and received bytes are dropped.
- R5: In mode 3, received bytes go only to the TX FIFO, and processor writes are dropped.
- R6: A direction accepts a byte only while its enable bit is 1 and its disable bit is 0. A processor read made while RX is blocked returns zero and removes nothing.
- R7: A byte sent to a full RX FIFO is discarded, and `rx_ovf_o` pulses for one cycle. The pulse happens in no other case. A byte sent to a full TX FIFO is discarded without a pulse.
- R8: The RX FIFO returns bytes in arrival order, on `cpu_rdata_o`, the cycle after the read strobe. A read of an empty RX FIFO returns zero.
- R9: Writing the control register with bit 0 (or bit 1) set empties the RX (or TX) FIFO. Those two bits always read back as zero.
- R10: After an accepted RX byte, `rx_tout_o` pulses on the 4*`char_ticks_i`-th following bit tick, if `tout_val_i` is nonzero and no new byte was accepted meanwhile. It pulses once per idle period.
- R11: Each accepted TX push pulses `tx_push_o` with its byte on `tx_push_data_o` in the next cycle. `tx_pop_i` removes the head `tx_head_o`, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control write data |
| ctrl_o | output | 9 | Stored control register |
| chan_mode_i | input | 2 | Channel mode 0..3 |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| cpu_wr_i | input | 1 | Processor data write strobe |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_rd_i | input | 1 | Processor data read strobe |
| cpu_rdata_o | output | 8 | Read data, valid the cycle after the read |
| tout_val_i | input | 8 | Timeout setting; zero disables the timeout |
| char_ticks_i | input | CTW | Bit ticks per character |
| bit_tick_i | input | 1 | Bit-time strobe |
| tx_pop_i | input | 1 | Remove the TX FIFO head |
| tx_head_o | output | 8 | TX FIFO head byte |
| rx_count_o | output | CW | RX FIFO occupancy |
| tx_count_o | output | CW | TX FIFO occupancy |
| rx_ovf_o | output | 1 | RX overflow pulse |
| rx_tout_o | output | 1 | Receive timeout pulse |
| tx_push_o | output | 1 | Byte entered the TX FIFO |
| tx_push_data_o | output | 8 | Byte that entered the TX FIFO |

## Verification
The assertions check on every cycle that:
- the reset-bit positions never read back as set;
- a clear leaves the RX FIFO empty;
- an overflow pulse only follows a full RX FIFO;
- the occupancy never exceeds the depth;
- a timeout pulse needs a nonzero setting and never repeats in the next cycle.

Only the bench's scenarios can show the rest:
- the routing in each of the four modes under every enable/disable combination;
- byte ordering through both FIFOs;
- the zero returned by blocked or empty reads;
- the exact bit tick on which the timeout fires, and its restart by a new byte.

// File: rtl/uartmr_pkg.sv
package uartmr_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ECHO   = 2'd1,
        MODE_LLOOP  = 2'd2,
        MODE_RLOOP  = 2'd3
    } chan_mode_e;

    localparam int CTRL_W       = 9;
    localparam int B_RX_CLR     = 0;
    localparam int B_TX_CLR     = 1;
    localparam int B_RX_EN      = 2;
    localparam int B_RX_DIS     = 3;
    localparam int B_TX_EN      = 4;
    localparam int B_TX_DIS     = 5;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
endpackage

// File: rtl/uartmr_fifo.sv
module uartmr_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;
    logic [AW-1:0] rptr;

    assign full_o  = (st_q.count == CW'(DEPTH));
    assign empty_o = (st_q.count == '0);
    assign rptr    = st_q.wptr - st_q.count[AW-1:0];
    assign head_o  = mem_q[rptr];
    assign count_o = st_q.count;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o && !clear_i;
        do_pop  = pop_i && !empty_o && !clear_i;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = st_q.wptr + AW'(1);
            st_d.count = st_q.count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_data_i;
    end
endmodule

// File: rtl/uartmr_route.sv
module uartmr_route
    import uartmr_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       rx_valid_i,
    input  logic       cpu_wr_i,
    input  logic       rx_ok_i,
    input  logic       tx_ok_i,
    output logic       rx_push_o,
    output logic       rx_from_cpu_o,
    output logic       tx_push_o,
    output logic       tx_from_line_o
);
    chan_mode_e mode;
    assign mode = chan_mode_e'(mode_i);

    always_comb begin
        rx_push_o      = 1'b0;
        rx_from_cpu_o  = 1'b0;
        tx_push_o      = 1'b0;
        tx_from_line_o = 1'b0;
        unique case (mode)
            MODE_NORMAL: begin
                rx_push_o = rx_valid_i && rx_ok_i;
                tx_push_o = cpu_wr_i && tx_ok_i;
            end
            MODE_ECHO: begin
                rx_push_o      = rx_valid_i && rx_ok_i;
                tx_push_o      = rx_valid_i && tx_ok_i;
                tx_from_line_o = 1'b1;
            end
            MODE_LLOOP: begin
                rx_push_o     = cpu_wr_i && rx_ok_i;
                rx_from_cpu_o = 1'b1;
            end
            MODE_RLOOP: begin
                tx_push_o      = rx_valid_i && tx_ok_i;
                tx_from_line_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/uartmr_idle_timer.sv
module uartmr_idle_timer #(
    parameter int CTW = 6,
    localparam int TW = CTW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart_i,
    input  logic           tick_i,
    input  logic [CTW-1:0] char_ticks_i,
    input  logic           enable_i,
    output logic           fire_o
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
        logic          fire;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (restart_i) begin
            st_d.cnt   = {char_ticks_i, 2'b00};
            st_d.armed = 1'b1;
        end else if (st_q.armed && tick_i) begin
            if (st_q.cnt <= TW'(1)) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.fire  = enable_i;
            end else begin
                st_d.cnt = st_q.cnt - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uartmr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CTW   = 6,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    input  logic [1:0]        chan_mode_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              cpu_wr_i,
    input  logic [7:0]        cpu_wdata_i,
    input  logic              cpu_rd_i,
    output logic [7:0]        cpu_rdata_o,
    input  logic [7:0]        tout_val_i,
    input  logic [CTW-1:0]    char_ticks_i,
    input  logic              bit_tick_i,
    input  logic              tx_pop_i,
    output logic [7:0]        tx_head_o,
    output logic [CW-1:0]     rx_count_o,
    output logic [CW-1:0]     tx_count_o,
    output logic              rx_ovf_o,
    output logic              rx_tout_o,
    output logic              tx_push_o,
    output logic [7:0]        tx_push_data_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [7:0]        rdata;
        logic              ovf;
        logic              txp;
        logic [7:0]        txp_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic       rx_ok, tx_ok;
    logic       rx_clear, tx_clear;
    logic       rx_req, rx_from_cpu, tx_req, tx_from_line;
    logic [7:0] rx_in, tx_in, rx_head;
    logic       rx_full, rx_empty, tx_full, tx_empty;
    logic       rd_ok, rx_accept;

    assign rx_ok    = st_q.ctrl[B_RX_EN] && !st_q.ctrl[B_RX_DIS];
    assign tx_ok    = st_q.ctrl[B_TX_EN] && !st_q.ctrl[B_TX_DIS];
    assign rx_clear = ctrl_wr_i && ctrl_wdata_i[B_RX_CLR];
    assign tx_clear = ctrl_wr_i && ctrl_wdata_i[B_TX_CLR];

    uartmr_route u_route (
        .mode_i         (chan_mode_i),
        .rx_valid_i     (rx_valid_i),
        .cpu_wr_i       (cpu_wr_i),
        .rx_ok_i        (rx_ok),
        .tx_ok_i        (tx_ok),
        .rx_push_o      (rx_req),
        .rx_from_cpu_o  (rx_from_cpu),
        .tx_push_o      (tx_req),
        .tx_from_line_o (tx_from_line)
    );

    assign rx_in     = rx_from_cpu ? cpu_wdata_i : rx_byte_i;
    assign tx_in     = tx_from_line ? rx_byte_i : cpu_wdata_i;
    assign rd_ok     = cpu_rd_i && rx_ok;
    assign rx_accept = rx_req && !rx_full && !rx_clear;

    uartmr_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (rx_clear),
        .push_i      (rx_req),
        .push_data_i (rx_in),
        .pop_i       (rd_ok),
        .head_o      (rx_head),
        .count_o     (rx_count_o),
        .full_o      (rx_full),
        .empty_o     (rx_empty)
    );

    uartmr_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (tx_clear),
        .push_i      (tx_req),
        .push_data_i (tx_in),
        .pop_i       (tx_pop_i),
        .head_o      (tx_head_o),
        .count_o     (tx_count_o),
        .full_o      (tx_full),
        .empty_o     (tx_empty)
    );

    uartmr_idle_timer #(.CTW(CTW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (rx_accept),
        .tick_i       (bit_tick_i),
        .char_ticks_i (char_ticks_i),
        .enable_i     (tout_val_i != 8'd0),
        .fire_o       (rx_tout_o)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ovf      = rx_req && rx_full && !rx_clear;
        st_d.txp      = tx_req && !tx_full && !tx_clear;
        st_d.txp_data = st_d.txp ? tx_in : st_q.txp_data;
        if (ctrl_wr_i) begin
            st_d.ctrl           = ctrl_wdata_i;
            st_d.ctrl[B_RX_CLR] = 1'b0;
            st_d.ctrl[B_TX_CLR] = 1'b0;
        end
        if (cpu_rd_i) begin
            st_d.rdata = (rd_ok && !rx_empty) ? rx_head : 8'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ctrl     <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o         = st_q.ctrl;
    assign cpu_rdata_o    = st_q.rdata;
    assign rx_ovf_o       = st_q.ovf;
    assign tx_push_o      = st_q.txp;
    assign tx_push_data_o = st_q.txp_data;
endmodule

// File: rtl/uartmr_checker.sv
module uartmr_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr_i,
    input logic [8:0]    ctrl_wdata_i,
    input logic [8:0]    ctrl_o,
    input logic [CW-1:0] rx_count_o,
    input logic [CW-1:0] tx_count_o,
    input logic          rx_ovf_o,
    input logic          rx_tout_o,
    input logic [7:0]    tout_val_i
);
    // R1: the first cycle out of reset shows the reset value
    a_r1_ctrl_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> ctrl_o == 9'h128);

    // R9: clear bits never stored
    a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[1:0] == 2'b00);

    // R9: a clear empties the RX FIFO
    a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[0]) |=> rx_count_o == '0);

    // R7: overflow only after a full RX FIFO
    a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_o |-> $past(rx_count_o) == CW'(DEPTH));

    // R8: occupancy bounded by the depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count_o <= CW'(DEPTH)) && (tx_count_o <= CW'(DEPTH)));

    // R10: timeout needs a nonzero setting
    a_r10_tout_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tout_o |-> $past(tout_val_i) != 8'd0);

    // R10: one pulse per idle period
    a_r10_tout_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tout_o |=> !rx_tout_o);
endmodule

bind uart_mode_router uartmr_checker #(.DEPTH(DEPTH)) i_uartmr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ctrl_o       (ctrl_o),
    .rx_count_o   (rx_count_o),
    .tx_count_o   (tx_count_o),
    .rx_ovf_o     (rx_ovf_o),
    .rx_tout_o    (rx_tout_o),
    .tout_val_i   (tout_val_i)
);

// File: tb/test_uart_mode_router.sv
module test_uart_mode_router;
    localparam int DEPTH = 8;
    localparam int CTW   = 4;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ctrl_wr_i = 1'b0;
    logic [8:0]     ctrl_wdata_i = '0;
    logic [8:0]     ctrl_o;
    logic [1:0]     chan_mode_i = 2'd0;
    logic           rx_valid_i = 1'b0;
    logic [7:0]     rx_byte_i = '0;
    logic           cpu_wr_i = 1'b0;
    logic [7:0]     cpu_wdata_i = '0;
    logic           cpu_rd_i = 1'b0;
    logic [7:0]     cpu_rdata_o;
    logic [7:0]     tout_val_i = '0;
    logic [CTW-1:0] char_ticks_i = '0;
    logic           bit_tick_i = 1'b0;
    logic           tx_pop_i = 1'b0;
    logic [7:0]     tx_head_o;
    logic [CW-1:0]  rx_count_o, tx_count_o;
    logic           rx_ovf_o, rx_tout_o, tx_push_o;
    logic [7:0]     tx_push_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    uart_mode_router #(.DEPTH(DEPTH), .CTW(CTW)) i_uart_mode_router (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive at negedge, release at next negedge: outputs then show the edge
    task automatic ctrl_write(input logic [8:0] v);
        @(negedge clk); ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
        @(negedge clk); ctrl_wr_i = 1'b0;
    endtask
    task automatic rx_send(input logic [7:0] b);
        @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk); rx_valid_i = 1'b0;
    endtask
    task automatic cpu_write(input logic [7:0] b);
        @(negedge clk); cpu_wr_i = 1'b1; cpu_wdata_i = b;
        @(negedge clk); cpu_wr_i = 1'b0;
    endtask
    task automatic cpu_read();
        @(negedge clk); cpu_rd_i = 1'b1;
        @(negedge clk); cpu_rd_i = 1'b0;
    endtask
    task automatic tx_pop();
        @(negedge clk); tx_pop_i = 1'b1;
        @(negedge clk); tx_pop_i = 1'b0;
    endtask
    task automatic tick();
        @(negedge clk); bit_tick_i = 1'b1;
        @(negedge clk); bit_tick_i = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctrl reset", int'(ctrl_o), 'h128);
        chk("R1 rx count reset", int'(rx_count_o), 0);
        chk("R1 tx count reset", int'(tx_count_o), 0);
        chk("R1 rdata reset", int'(cpu_rdata_o), 0);
        rx_send(8'h11);
        cpu_write(8'h22);
        chk("R1 rx blocked after reset", int'(rx_count_o), 0);
        chk("R1 tx blocked after reset", int'(tx_count_o), 0);

        // R2..R6 sweep: every mode against every enable/disable combination
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 16; e++) begin
                bit rok, tok;
                int erx, etx;
                rok = e[0] && !e[1];
                tok = e[2] && !e[3];
                chan_mode_i = 2'(m);
                ctrl_write(9'(3 | (e << 2)));
                chk("R9 clear readback", int'(ctrl_o), e << 2);
                chk("R9 clear rx", int'(rx_count_o), 0);
                chk("R9 clear tx", int'(tx_count_o), 0);
                rx_send(8'(8'hA0 + m));
                cpu_write(8'(8'hB0 + m));
                erx = ((m <= 1 || m == 2) && rok) ? 1 : 0;
                etx = ((m == 0 || m == 1 || m == 3) && tok) ? 1 : 0;
                chk(m == 0 ? "R2 rx count" : m == 1 ? "R3 rx count" :
                    m == 2 ? "R4 rx count" : "R5 rx count", int'(rx_count_o), erx);
                chk(m == 0 ? "R2 tx count" : m == 1 ? "R3 tx count" :
                    m == 2 ? "R4 tx count" : "R5 tx count", int'(tx_count_o), etx);
                if (erx == 1) begin
                    cpu_read();
                    chk("R2 R3 R4 rx data", int'(cpu_rdata_o),
                        m == 2 ? 'hB2 : 'hA0 + m);
                end
                if (etx == 1)
                    chk("R11 tx head", int'(tx_head_o), m == 0 ? 'hB0 : 'hA0 + m);
            end
        end

        // R11: push pulse and data
        chan_mode_i = 2'd1;
        ctrl_write(9'h017);
        rx_send(8'h5A);
        chk("R11 push pulse", int'(tx_push_o), 1);
        chk("R11 push data", int'(tx_push_data_o), 'h5A);
        @(negedge clk);
        chk("R11 push pulse ends", int'(tx_push_o), 0);

        // R7/R8: fill, overflow, ordered drain, empty read
        chan_mode_i = 2'd0;
        ctrl_write(9'h017);
        for (int i = 0; i < DEPTH; i++) begin
            rx_send(8'(8'h30 + i));
            chk("R7 no ovf below full", int'(rx_ovf_o), 0);
        end
        chk("R8 full count", int'(rx_count_o), DEPTH);
        rx_send(8'hEE);
        chk("R7 ovf pulse", int'(rx_ovf_o), 1);
        chk("R7 count kept", int'(rx_count_o), DEPTH);
        @(negedge clk);
        chk("R7 ovf single", int'(rx_ovf_o), 0);
        for (int i = 0; i < DEPTH; i++) begin
            cpu_read();
            chk("R8 order", int'(cpu_rdata_o), 'h30 + i);
        end
        cpu_read();
        chk("R8 empty read zero", int'(cpu_rdata_o), 0);
        chk("R8 empty count", int'(rx_count_o), 0);

        // R6: blocked read returns zero and keeps the byte
        rx_send(8'h77);
        ctrl_write(9'h01C);
        cpu_read();
        chk("R6 blocked read zero", int'(cpu_rdata_o), 0);
        chk("R6 blocked read no pop", int'(rx_count_o), 1);
        ctrl_write(9'h014);
        cpu_read();
        chk("R6 read after enable", int'(cpu_rdata_o), 'h77);

        // R11/R7: TX order, full TX drop without ovf
        ctrl_write(9'h017);
        for (int i = 0; i < DEPTH + 1; i++) begin
            cpu_write(8'(8'h60 + i));
            chk("R7 no ovf on tx", int'(rx_ovf_o), 0);
        end
        chk("R7 tx full count", int'(tx_count_o), DEPTH);
        for (int i = 0; i < 3; i++) begin
            chk("R11 tx pop order", int'(tx_head_o), 'h60 + i);
            tx_pop();
        end
        chk("R11 tx count after pops", int'(tx_count_o), DEPTH - 3);

        // R10: timeout after 4*char_ticks bit ticks
        char_ticks_i = 4'd2;
        tout_val_i   = 8'd5;
        ctrl_write(9'h017);
        rx_send(8'h01);
        for (int t = 1; t < 8; t++) begin
            tick();
            chk("R10 no early tout", int'(rx_tout_o), 0);
        end
        tick();
        chk("R10 tout fires", int'(rx_tout_o), 1);
        @(negedge clk);
        chk("R10 tout single", int'(rx_tout_o), 0);
        tick();
        chk("R10 no rearm", int'(rx_tout_o), 0);
        rx_send(8'h02);
        for (int t = 0; t < 5; t++) tick();
        rx_send(8'h03);
        for (int t = 1; t < 8; t++) begin
            tick();
            chk("R10 restart delays tout", int'(rx_tout_o), 0);
        end
        tick();
        chk("R10 tout after restart", int'(rx_tout_o), 1);
        tout_val_i = 8'd0;
        rx_send(8'h04);
        for (int t = 0; t < 10; t++) begin
            tick();
            chk("R10 disabled by zero", int'(rx_tout_o), 0);
        end

        done = 1'b1;
        summary();
    end
endmodule